// File: doc/BRIEF.md
# Multiplexed Bus Address Latch and Data Buffer

This block sits beside a processor whose bus shares its pins between address, data and status. At the start of each bus cycle the processor raises an address strobe for one clock. The block then captures the low address bits from the shared address/data lines. It also captures the upper address bits from the lines that later carry status, and the active-low high-byte enable. All of these are held on a dedicated address output until the next strobe. Meanwhile the shared lines are free to carry data and status.

A second section buffers data between the shared lines and a system data bus, one byte lane at a time. A direction input picks the flow. A data enable input either connects the two sides or isolates both of them. High impedance is modelled with an explicit drive flag next to each output bus. A bus whose flag is low reads as all zeros, and the pad ring turns the flag into a real tri-state.

Top module: `bus_demux_latch`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, the held address becomes all zeros and the held high-byte enable becomes 1 (inactive). Both are visible from that edge on.
- R2: On a rising edge where `ale` is high, bits 15:0 of the held address load from `ad_i`. The value appears on `addr_o[15:0]` right after that edge.
- R3: On a rising edge where `ale` is high, bits 19:16 of the held address load from `ast_i`.
- R4: The high-byte enable `bhe_n_i` is captured on the same edges as the address and appears on `bhe_n_o`.
- R5: On a rising edge where `ale` is low, the held address and high-byte enable keep their value, whatever `ad_i`, `ast_i` and `bhe_n_i` do.
- R6: While `addr_oe` is low, `addr_drive_o` is 0 and both `addr_o` and `bhe_n_o` read 0. The held value is not disturbed and reappears when `addr_oe` returns high. While `addr_oe` is high, `addr_drive_o` is 1.
- R7: While `data_en` is high and `dir_tx` is 1 (transmit), `sys_d_o` equals `ad_i`, `sys_drive_o` is 1 and `proc_drive_o` is 0, with no clock delay.
- R8: While `data_en` is high and `dir_tx` is 0 (receive), `proc_d_o` equals `sys_d_i`, `proc_drive_o` is 1 and `sys_drive_o` is 0, with no clock delay.
- R9: While `data_en` is low, both `sys_drive_o` and `proc_drive_o` are 0, and `sys_d_o` and `proc_d_o` read 0.
- R10: Strobes on back-to-back edges each load a fresh address; no strobe is lost or merged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ale | input | 1 | Address strobe, sampled on rising edges |
| ad_i | input | 16 | Shared address/data lines, processor side |
| ast_i | input | 4 | Shared upper address/status lines |
| bhe_n_i | input | 1 | Active-low high-byte enable from the processor |
| addr_oe | input | 1 | Drive enable for the held address outputs |
| addr_o | output | 20 | Held 20-bit address (0 while not driven) |
| bhe_n_o | output | 1 | Held high-byte enable (0 while not driven) |
| addr_drive_o | output | 1 | High while the address outputs are driven |
| dir_tx | input | 1 | 1 = toward system bus, 0 = toward processor |
| data_en | input | 1 | Connects the data sides when high |
| sys_d_i | input | 16 | System data bus, incoming |
| sys_d_o | output | 16 | Data driven onto the system bus |
| sys_drive_o | output | 1 | High while `sys_d_o` is driven |
| proc_d_o | output | 16 | Data driven back onto the shared lines |
| proc_drive_o | output | 1 | High while `proc_d_o` is driven |

## Verification
The assertions assume that `ale`, `addr_oe`, `dir_tx` and `data_en` are known, clean levels at every rising edge. They also assume that `rst_n` is known from the first edge, so past-value comparisons are taken only after reset is released. The bench changes every input only on falling edges. It holds `ale` for single clocks, for back-to-back runs and for long gaps. It moves the shared lines during gaps, so the hold behaviour is exercised under changing inputs.

// File: rtl/bus_demux_pkg.sv
// Package: shared constants and the direction encoding for the bus
// demultiplexer. Assumes a byte-organised data path.
package bus_demux_pkg;

    localparam int unsigned BYTE_W = 8;

    // Direction of the data buffer; the value is the level of dir_tx.
    typedef enum logic {
        FLOW_TO_PROC = 1'b0,
        FLOW_TO_SYS  = 1'b1
    } flow_dir_e;

endpackage

// File: rtl/addr_capture.sv
// Module: addr_capture
// Holds the address and high-byte enable sampled from the shared lines.
// Assumes the strobe is synchronous to clk; loads on every edge it is high.
module addr_capture #(
    parameter int unsigned LO_W = 16,
    parameter int unsigned HI_W = 4,
    localparam int unsigned ADDR_W = LO_W + HI_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              strobe,
    input  logic [LO_W-1:0]   lo_i,
    input  logic [HI_W-1:0]   hi_i,
    input  logic              bhe_n_i,
    output logic [ADDR_W-1:0] addr_q,
    output logic              bhe_n_q
);

    // Capture register: reset clears it, strobe loads it, otherwise it holds.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            bhe_n_q <= 1'b1;
        end else if (strobe) begin
            addr_q  <= {hi_i, lo_i};
            bhe_n_q <= bhe_n_i;
        end
    end

endmodule

// File: rtl/addr_driver.sv
// Module: addr_driver
// Gates the held address onto the output pins with an explicit drive flag.
// Assumes a pad ring that turns drive_o into a real tri-state.
module addr_driver #(
    parameter int unsigned ADDR_W = 20
) (
    input  logic              oe,
    input  logic [ADDR_W-1:0] addr_q,
    input  logic              bhe_n_q,
    output logic [ADDR_W-1:0] addr_o,
    output logic              bhe_n_o,
    output logic              drive_o
);

    // Output gate: floating outputs read as zero.
    always_comb begin
        drive_o = oe;
        addr_o  = oe ? addr_q : '0;
        bhe_n_o = oe ? bhe_n_q : 1'b0;
    end

endmodule

// File: rtl/data_lane.sv
// Module: data_lane
// One byte lane of the bidirectional data buffer. Purely combinational;
// assumes the direction and enable have been decoded by the caller.
module data_lane #(
    parameter int unsigned W = 8
) (
    input  logic         to_sys,
    input  logic         to_proc,
    input  logic [W-1:0] proc_i,
    input  logic [W-1:0] sys_i,
    output logic [W-1:0] sys_o,
    output logic [W-1:0] proc_o
);

    // Lane steering: each side sees data only when its path is open.
    always_comb begin
        sys_o  = to_sys  ? proc_i : '0;
        proc_o = to_proc ? sys_i  : '0;
    end

endmodule

// File: rtl/bus_demux_latch.sv
// Module: bus_demux_latch (top)
// Splits a multiplexed address/data/status bus into a held 20-bit address
// and a direction-steered, isolatable data buffer. Assumes all control
// inputs are synchronous to clk and reset is synchronous active-low.
module bus_demux_latch #(
    parameter int unsigned AD_W = 16,
    parameter int unsigned HI_W = 4,
    localparam int unsigned ADDR_W = AD_W + HI_W,
    localparam int unsigned LANES  = AD_W / bus_demux_pkg::BYTE_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ale,
    input  logic [AD_W-1:0]   ad_i,
    input  logic [HI_W-1:0]   ast_i,
    input  logic              bhe_n_i,
    input  logic              addr_oe,
    output logic [ADDR_W-1:0] addr_o,
    output logic              bhe_n_o,
    output logic              addr_drive_o,
    input  logic              dir_tx,
    input  logic              data_en,
    input  logic [AD_W-1:0]   sys_d_i,
    output logic [AD_W-1:0]   sys_d_o,
    output logic              sys_drive_o,
    output logic [AD_W-1:0]   proc_d_o,
    output logic              proc_drive_o
);
    import bus_demux_pkg::*;

    logic [ADDR_W-1:0] held_addr;
    logic              held_bhe_n;
    flow_dir_e         flow;
    logic              open_sys;
    logic              open_proc;

    addr_capture #(.LO_W(AD_W), .HI_W(HI_W)) u_capture (
        .clk     (clk),
        .rst_n   (rst_n),
        .strobe  (ale),
        .lo_i    (ad_i),
        .hi_i    (ast_i),
        .bhe_n_i (bhe_n_i),
        .addr_q  (held_addr),
        .bhe_n_q (held_bhe_n)
    );

    addr_driver #(.ADDR_W(ADDR_W)) u_driver (
        .oe      (addr_oe),
        .addr_q  (held_addr),
        .bhe_n_q (held_bhe_n),
        .addr_o  (addr_o),
        .bhe_n_o (bhe_n_o),
        .drive_o (addr_drive_o)
    );

    // Path decode: one side at most is opened, and only while enabled.
    always_comb begin
        flow      = flow_dir_e'(dir_tx);
        open_sys  = data_en && (flow == FLOW_TO_SYS);
        open_proc = data_en && (flow == FLOW_TO_PROC);
    end

    assign sys_drive_o  = open_sys;
    assign proc_drive_o = open_proc;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        data_lane #(.W(BYTE_W)) u_lane (
            .to_sys  (open_sys),
            .to_proc (open_proc),
            .proc_i  (ad_i[g*BYTE_W +: BYTE_W]),
            .sys_i   (sys_d_i[g*BYTE_W +: BYTE_W]),
            .sys_o   (sys_d_o[g*BYTE_W +: BYTE_W]),
            .proc_o  (proc_d_o[g*BYTE_W +: BYTE_W])
        );
    end

endmodule

// File: rtl/bus_demux_latch_chk.sv
// Module: bus_demux_latch_chk
// Property checker bound to bus_demux_latch. Assumes clean control levels
// at every rising edge and a known reset from the first edge.
module bus_demux_latch_chk #(
    parameter int unsigned AD_W = 16,
    parameter int unsigned HI_W = 4,
    localparam int unsigned ADDR_W = AD_W + HI_W
) (
    input logic              clk,
    input logic              rst_n,
    input logic              ale,
    input logic [AD_W-1:0]   ad_i,
    input logic [HI_W-1:0]   ast_i,
    input logic              bhe_n_i,
    input logic              addr_oe,
    input logic [ADDR_W-1:0] addr_o,
    input logic              bhe_n_o,
    input logic              addr_drive_o,
    input logic              dir_tx,
    input logic              data_en,
    input logic [AD_W-1:0]   sys_d_i,
    input logic [AD_W-1:0]   sys_d_o,
    input logic              sys_drive_o,
    input logic [AD_W-1:0]   proc_d_o,
    input logic              proc_drive_o,
    input logic [ADDR_W-1:0] held_addr,
    input logic              held_bhe_n
);

    assert_reset_clear_R1: assert property (@(posedge clk)
        !rst_n |=> (held_addr == '0 && held_bhe_n == 1'b1));

    assert_low_load_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> held_addr[AD_W-1:0] == $past(ad_i));

    assert_high_load_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> held_addr[ADDR_W-1:AD_W] == $past(ast_i));

    assert_bhe_load_R4: assert property (@(posedge clk) disable iff (!rst_n)
        ale |=> held_bhe_n == $past(bhe_n_i));

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !ale |=> ($stable(held_addr) && $stable(held_bhe_n)));

    assert_float_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_oe |-> (!addr_drive_o && addr_o == '0 && !bhe_n_o));

    assert_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
        addr_oe |-> (addr_drive_o && addr_o == held_addr));

    assert_transmit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (data_en && dir_tx) |-> (sys_drive_o && !proc_drive_o && sys_d_o == ad_i));

    assert_receive_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (data_en && !dir_tx) |-> (proc_drive_o && !sys_drive_o && proc_d_o == sys_d_i));

    assert_isolate_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !data_en |-> (!sys_drive_o && !proc_drive_o && sys_d_o == '0 && proc_d_o == '0));

    assert_one_side_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({sys_drive_o, proc_drive_o}) <= 1);

endmodule

bind bus_demux_latch bus_demux_latch_chk #(.AD_W(AD_W), .HI_W(HI_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ale          (ale),
    .ad_i         (ad_i),
    .ast_i        (ast_i),
    .bhe_n_i      (bhe_n_i),
    .addr_oe      (addr_oe),
    .addr_o       (addr_o),
    .bhe_n_o      (bhe_n_o),
    .addr_drive_o (addr_drive_o),
    .dir_tx       (dir_tx),
    .data_en      (data_en),
    .sys_d_i      (sys_d_i),
    .sys_d_o      (sys_d_o),
    .sys_drive_o  (sys_drive_o),
    .proc_d_o     (proc_d_o),
    .proc_drive_o (proc_drive_o),
    .held_addr    (held_addr),
    .held_bhe_n   (held_bhe_n)
);

// File: tb/test_bus_demux_latch.sv
// Bench for bus_demux_latch: a behavioural reference model is updated at
// each rising edge and every output is compared once per clock, mid-cycle.
module test_bus_demux_latch;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_CYCLES = 5000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ale = 1'b0;
    logic [15:0] ad_i = '0;
    logic [3:0]  ast_i = '0;
    logic        bhe_n_i = 1'b1;
    logic        addr_oe = 1'b1;
    logic [19:0] addr_o;
    logic        bhe_n_o;
    logic        addr_drive_o;
    logic        dir_tx = 1'b0;
    logic        data_en = 1'b0;
    logic [15:0] sys_d_i = '0;
    logic [15:0] sys_d_o;
    logic        sys_drive_o;
    logic [15:0] proc_d_o;
    logic        proc_drive_o;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done = 1'b0;

    // Reference state
    int  m_addr = 0;
    bit  m_bhe_n = 1'b1;
    bit  prev_ale = 1'b0;
    bit  prev_rst = 1'b1;

    bus_demux_latch i_bus_demux_latch (
        .clk(clk), .rst_n(rst_n), .ale(ale), .ad_i(ad_i), .ast_i(ast_i),
        .bhe_n_i(bhe_n_i), .addr_oe(addr_oe), .addr_o(addr_o),
        .bhe_n_o(bhe_n_o), .addr_drive_o(addr_drive_o), .dir_tx(dir_tx),
        .data_en(data_en), .sys_d_i(sys_d_i), .sys_d_o(sys_d_o),
        .sys_drive_o(sys_drive_o), .proc_d_o(proc_d_o),
        .proc_drive_o(proc_drive_o)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", req, act, exp);
        end
    endtask

    // One clock: update the model at the edge, compare half a period later.
    task automatic tick();
        string tag;
        @(posedge clk);
        cycles++;
        prev_rst = !rst_n;
        prev_ale = ale;
        if (!rst_n) begin
            m_addr  = 0;
            m_bhe_n = 1'b1;
        end else if (ale) begin
            m_addr  = {12'd0, ast_i, ad_i};
            m_bhe_n = bhe_n_i;
        end
        #(CLK_PERIOD/2);
        compare();
    endtask

    task automatic compare();
        if (!addr_oe) begin
            check("R6 drive flag", 32'(addr_drive_o), 32'd0);
            check("R6 floating address", 32'(addr_o), 32'd0);
            check("R6 floating bhe", 32'(bhe_n_o), 32'd0);
        end else begin
            check("R6 drive flag", 32'(addr_drive_o), 32'd1);
            if (prev_rst) begin
                check("R1 reset address", 32'(addr_o), 32'(m_addr));
                check("R1 reset bhe", 32'(bhe_n_o), 32'(m_bhe_n));
            end else if (prev_ale) begin
                check("R2/R10 low address", 32'(addr_o[15:0]), 32'(m_addr[15:0]));
                check("R3 high address", 32'(addr_o[19:16]), 32'(m_addr[19:16]));
                check("R4 bhe capture", 32'(bhe_n_o), 32'(m_bhe_n));
            end else begin
                check("R5 held address", 32'(addr_o), 32'(m_addr));
                check("R5 held bhe", 32'(bhe_n_o), 32'(m_bhe_n));
            end
        end
        if (!data_en) begin
            check("R9 isolate sys drive", 32'(sys_drive_o), 32'd0);
            check("R9 isolate proc drive", 32'(proc_drive_o), 32'd0);
            check("R9 isolate data", {sys_d_o, proc_d_o}, 32'd0);
        end else if (dir_tx) begin
            check("R7 transmit drives", {30'd0, sys_drive_o, proc_drive_o}, 32'd2);
            check("R7 transmit data", 32'(sys_d_o), 32'(ad_i));
        end else begin
            check("R8 receive drives", {30'd0, sys_drive_o, proc_drive_o}, 32'd1);
            check("R8 receive data", 32'(proc_d_o), 32'(sys_d_i));
        end
    endtask

    task automatic strobe(input logic [15:0] lo, input logic [3:0] hi, input logic bhe);
        ale = 1'b1; ad_i = lo; ast_i = hi; bhe_n_i = bhe;
        tick();
        ale = 1'b0; ad_i = ~lo; ast_i = ~hi; bhe_n_i = ~bhe;
    endtask

    // Watchdog: a hung run counts as one failed check.
    initial begin
        #(CLK_PERIOD * MAX_CYCLES);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog actual timeout expected finish");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        // R1: reset state with junk on the inputs and strobe high
        ale = 1'b1; ad_i = 16'hDEAD; ast_i = 4'hF; bhe_n_i = 1'b0;
        repeat (3) tick();
        @(negedge clk);
        rst_n = 1'b1; ale = 1'b0;
        tick();

        // R2, R3, R4: single strobes with several patterns
        strobe(16'h1234, 4'hA, 1'b0); tick(); tick();
        strobe(16'hFFFF, 4'hF, 1'b1); tick();
        strobe(16'h0000, 4'h0, 1'b0); tick();
        strobe(16'h8001, 4'h8, 1'b1);

        // R5: long hold while inputs churn
        for (int i = 0; i < 20; i++) begin
            ad_i = 16'(i * 16'h1357); ast_i = 4'(i); bhe_n_i = i[0];
            tick();
        end

        // R10: back-to-back strobes
        for (int i = 0; i < 8; i++) begin
            ale = 1'b1; ad_i = 16'(16'hA5A5 ^ (i * 16'h0F0F));
            ast_i = 4'(i * 3); bhe_n_i = i[1];
            tick();
        end
        ale = 1'b0; ad_i = 16'h5555; tick();

        // R6: float and return
        addr_oe = 1'b0; tick(); tick();
        strobe(16'hCAFE, 4'h3, 1'b0);
        tick();
        addr_oe = 1'b1; tick(); tick();

        // R7, R8, R9: data buffer in all modes
        for (int i = 0; i < 24; i++) begin
            data_en = (i % 3) != 0;
            dir_tx  = i[0];
            ad_i    = 16'(i * 16'h2468 + 1);
            sys_d_i = 16'(16'hF00F ^ (i * 16'h1111));
            ale     = (i % 5) == 0;
            ast_i   = 4'(i);
            tick();
        end
        ale = 1'b0; data_en = 1'b0; tick();

        // R1 again: reset mid-run clears the held value
        rst_n = 1'b0; tick();
        rst_n = 1'b1; tick();

        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule